// File: doc/BRIEF.md
# Read-Only Cache with Victim Buffer

This block is a read path. A direct-mapped level-one array sits in front of a small fully associative victim buffer that holds lines recently pushed out of the array. Each request carries a block address. The array is searched first. The buffer is searched only when the array misses. When the buffer holds the line, that line returns to the array and the line it displaces takes the freed buffer slot. When neither structure holds the line, it is fetched from next-level memory. The displaced array line is then parked in the buffer, and whatever the buffer has to drop leaves on an eviction port.

Each buffer entry keeps the whole block address, because its position does not imply an array index. A new buffer entry goes into the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the slot, so entries leave in first-in order. Each request is accepted with a single-cycle valid/ready exchange, and the response is a one-cycle pulse carrying the line.

Top module: `vc_cache_top`

## Requirements
- R1: After reset, all array lines and buffer entries are empty, `req_ready_o` is 1, and `resp_valid_o`, `mem_req_valid_o` and `evict_valid_o` are 0. The first access to any address is a miss.
- R2: On an array hit, `resp_valid_o` pulses with the line data in the cycle after acceptance, and no memory request is made.
- R3: On an array miss that hits the buffer, the response comes two cycles after acceptance with the buffer's data, and no memory request is made.
- R4: After a buffer hit, the requested line sits in the array, so its next access is an array hit. The displaced array line sits in the same buffer entry, so its next access is a buffer hit. The buffer never holds two entries with the same address.
- R5: On a miss in both structures, `mem_req_valid_o` rises in the cycle after acceptance with `mem_req_addr_o` equal to the block address. It holds until `mem_resp_valid_i`. The response carries `mem_resp_data_i` in the following cycle, and the line is installed in the array.
- R6: On a miss in both structures, a valid displaced array line is inserted into the buffer. An empty displaced line is not inserted.
- R7: The insertion slot is the lowest-index empty entry. If there is none, it is the entry at a pointer that starts at 0 and advances by one, modulo 4, on each such insertion. A valid entry replaced this way appears on `evict_addr_o` and `evict_data_o`, with `evict_valid_o` pulsing in the same cycle as the response.
- R8: `evict_valid_o` stays 0 on array hits, on buffer hits, and when the slot being filled is empty.
- R9: `req_ready_o` is 0 from the cycle after accepting a buffer-hit or a full-miss request until its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Block address of request |
| req_ready_o | output | 1 | Block can accept a request |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_data_o | output | DATA_W | Returned line |
| mem_req_valid_o | output | 1 | Fetch request to next level |
| mem_req_addr_o | output | ADDR_W | Block address to fetch |
| mem_resp_valid_i | input | 1 | Fetched line present |
| mem_resp_data_i | input | DATA_W | Fetched line |
| evict_valid_o | output | 1 | Evicted buffer line present |
| evict_addr_o | output | ADDR_W | Address of evicted line |
| evict_data_o | output | DATA_W | Data of evicted line |

## Verification
The bench targets these corner cases:

- **Swap in both directions.** Two addresses that share an array index are ping-ponged between the array and the buffer. A design that copied the line instead of swapping it would leave a duplicate, or lose the displaced line and miss to memory.
- **Buffer fill and FIFO eviction.** Conflicting misses first fill the buffer and then overflow it. An error in the empty-slot priority or in the pointer shows up as a wrong eviction address, or as an eviction pulse while empty slots remain.
- **Empty displaced line.** The first fill of each index checks that an empty line is never parked in the buffer. Parking it would cause a false eviction later.
- **Latency and handshake.** Random memory delays check that the fetch request is held, and that each outcome responds in its stated cycle.

// File: rtl/vc_cache_pkg.sv
package vc_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_FETCH = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/vc_l1_array.sv
module vc_l1_array #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic              old_valid_o,
  output logic [ADDR_W-1:0] old_addr_o,
  output logic [DATA_W-1:0] old_data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = look_addr_i[IDX_W-1:0];
  assign tag = look_addr_i[ADDR_W-1:IDX_W];

  assign old_valid_o = valid_q[idx];
  assign old_addr_o  = {tag_q[idx], idx};
  assign old_data_o  = data_q[idx];
  assign hit_o       = valid_q[idx] && (tag_q[idx] == tag);

  // writes always target the line indexed by the lookup address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= wr_data_i;
    end
  end

  // R5
  installed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && $stable(look_addr_i) |=> hit_o);
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              swap_en_i,
  input  logic              swap_valid_i,
  input  logic [ADDR_W-1:0] swap_addr_i,
  input  logic [DATA_W-1:0] swap_data_i,
  input  logic              ins_en_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  output logic              vict_valid_o,
  output logic [ADDR_W-1:0] vict_addr_o,
  output logic [DATA_W-1:0] vict_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  valid_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;

  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] hit_idx, free_idx, sel_idx;
  logic             any_free;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (addr_q[g] == look_addr_i);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i])    hit_idx  = PTR_W'(i);
      if (!valid_q[i]) begin
        free_idx = PTR_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign hit_o        = |match;
  assign hit_data_o   = data_q[hit_idx];
  assign sel_idx      = any_free ? free_idx : ptr_q;
  assign vict_valid_o = valid_q[sel_idx];
  assign vict_addr_o  = addr_q[sel_idx];
  assign vict_data_o  = data_q[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (swap_en_i) begin
      valid_q[hit_idx] <= swap_valid_i;
    end else if (ins_en_i) begin
      valid_q[sel_idx] <= 1'b1;
      if (!any_free) ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (swap_en_i) begin
      addr_q[hit_idx] <= swap_addr_i;
      data_q[hit_idx] <= swap_data_i;
    end else if (ins_en_i) begin
      addr_q[sel_idx] <= ins_addr_i;
      data_q[sel_idx] <= ins_data_i;
    end
  end

  // R4
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R6
  fill_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_en_i && !swap_en_i && !vict_valid_o |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1);
endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top
  import vc_cache_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 3,
  parameter int DATA_W   = 32,
  parameter int VB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_resp_valid_i,
  input  logic [DATA_W-1:0] mem_resp_data_i,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic [DATA_W-1:0] evict_data_o
);
  ctl_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q, look_addr;
  logic              accept;

  logic              l1_hit, l1_old_valid, l1_wr_en;
  logic [ADDR_W-1:0] l1_old_addr;
  logic [DATA_W-1:0] l1_old_data, l1_wr_data;

  logic              vb_hit, vb_swap_en, vb_ins_en, vb_vict_valid;
  logic [DATA_W-1:0] vb_hit_data, vb_vict_data;
  logic [ADDR_W-1:0] vb_vict_addr;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept          = req_valid_i && req_ready_o;
  assign look_addr       = (state_q == ST_IDLE) ? req_addr_i : cur_addr_q;
  assign mem_req_valid_o = (state_q == ST_FETCH);
  assign mem_req_addr_o  = cur_addr_q;

  vc_l1_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_l1 (
    .clk_i, .rst_ni,
    .look_addr_i (look_addr),
    .hit_o       (l1_hit),
    .old_valid_o (l1_old_valid),
    .old_addr_o  (l1_old_addr),
    .old_data_o  (l1_old_data),
    .wr_en_i     (l1_wr_en),
    .wr_data_i   (l1_wr_data)
  );

  vc_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(VB_DEPTH)) u_vb (
    .clk_i, .rst_ni,
    .look_addr_i  (look_addr),
    .hit_o        (vb_hit),
    .hit_data_o   (vb_hit_data),
    .swap_en_i    (vb_swap_en),
    .swap_valid_i (l1_old_valid),
    .swap_addr_i  (l1_old_addr),
    .swap_data_i  (l1_old_data),
    .ins_en_i     (vb_ins_en),
    .ins_addr_i   (l1_old_addr),
    .ins_data_i   (l1_old_data),
    .vict_valid_o (vb_vict_valid),
    .vict_addr_o  (vb_vict_addr),
    .vict_data_o  (vb_vict_data)
  );

  always_comb begin
    l1_wr_en   = 1'b0;
    l1_wr_data = vb_hit_data;
    vb_swap_en = 1'b0;
    vb_ins_en  = 1'b0;
    if (state_q == ST_SWAP) begin
      l1_wr_en   = 1'b1;
      vb_swap_en = 1'b1;
    end else if (state_q == ST_FETCH && mem_resp_valid_i) begin
      l1_wr_en   = 1'b1;
      l1_wr_data = mem_resp_data_i;
      vb_ins_en  = l1_old_valid;   // empty displaced line is not parked
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cur_addr_q    <= '0;
      resp_valid_o  <= 1'b0;
      resp_data_o   <= '0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
      evict_data_o  <= '0;
    end else begin
      resp_valid_o  <= 1'b0;
      evict_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_addr_q <= req_addr_i;
          if (l1_hit) begin
            resp_valid_o <= 1'b1;
            resp_data_o  <= l1_old_data;
          end else if (vb_hit) begin
            state_q <= ST_SWAP;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_SWAP: begin
          resp_valid_o <= 1'b1;
          resp_data_o  <= vb_hit_data;
          state_q      <= ST_IDLE;
        end
        ST_FETCH: if (mem_resp_valid_i) begin
          resp_valid_o  <= 1'b1;
          resp_data_o   <= mem_resp_data_i;
          evict_valid_o <= vb_ins_en && vb_vict_valid;
          evict_addr_o  <= vb_vict_addr;
          evict_data_o  <= vb_vict_data;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  l1_hit_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && l1_hit |=> resp_valid_o && !mem_req_valid_o);

  // R9
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_resp_valid_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R7
  evict_with_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> resp_valid_o);
endmodule

// File: tb/vc_cache_top_bench.sv
`timescale 1ns/1ps
module vc_cache_top_bench;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_ready_o;
  logic          resp_valid_o;
  logic [DW-1:0] resp_data_o;
  logic          mem_req_valid_o;
  logic [AW-1:0] mem_req_addr_o;
  logic          mem_resp_valid_i = 1'b0;
  logic [DW-1:0] mem_resp_data_i = '0;
  logic          evict_valid_o;
  logic [AW-1:0] evict_addr_o;
  logic [DW-1:0] evict_data_o;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  bit            m_l1_v [8];
  logic [AW-1:0] m_l1_a [8];
  bit            m_vb_v [4];
  logic [AW-1:0] m_vb_a [4];
  int            m_ptr = 0;

  always #10 clk_i = ~clk_i;

  vc_cache_top u_vc_cache_top (.*);

  function automatic logic [DW-1:0] line_of(logic [AW-1:0] a);
    return {4'hC, a, ~a[7:0], a[11:4]};
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a);
    int idx, j, kind, slot, dly;
    bit ev_v;
    logic [AW-1:0] ev_a;
    idx  = int'(a[2:0]);
    j    = -1;
    ev_v = 1'b0;
    ev_a = '0;
    slot = -1;
    for (int k = 0; k < 4; k++) if (m_vb_v[k] && m_vb_a[k] == a) j = k;
    if (m_l1_v[idx] && m_l1_a[idx] == a) kind = 0;
    else if (j >= 0) kind = 1;
    else kind = 2;
    // model update
    if (kind == 1) begin
      m_vb_v[j] = m_l1_v[idx];
      m_vb_a[j] = m_l1_a[idx];
    end else if (kind == 2 && m_l1_v[idx]) begin
      for (int k = 3; k >= 0; k--) if (!m_vb_v[k]) slot = k;
      if (slot < 0) begin
        slot  = m_ptr;
        m_ptr = (m_ptr + 1) % 4;
      end
      ev_v = m_vb_v[slot];
      ev_a = m_vb_a[slot];
      m_vb_v[slot] = 1'b1;
      m_vb_a[slot] = m_l1_a[idx];
    end
    m_l1_v[idx] = 1'b1;
    m_l1_a[idx] = a;

    @(negedge clk_i);
    chk("R9", "ready before request", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (kind == 0) begin
      chk("R2", "hit resp_valid", 32'(resp_valid_o), 32'd1);
      chk("R2", "hit data", resp_data_o, line_of(a));
      chk("R2", "hit no mem req", 32'(mem_req_valid_o), 32'd0);
      chk("R8", "hit no evict", 32'(evict_valid_o), 32'd0);
    end else if (kind == 1) begin
      chk("R3", "vb early resp", 32'(resp_valid_o), 32'd0);
      chk("R3", "vb no mem req", 32'(mem_req_valid_o), 32'd0);
      chk("R9", "vb busy", 32'(req_ready_o), 32'd0);
      @(negedge clk_i);
      chk("R3", "vb resp_valid", 32'(resp_valid_o), 32'd1);
      chk("R4", "vb swap data", resp_data_o, line_of(a));
      chk("R8", "vb no evict", 32'(evict_valid_o), 32'd0);
    end else begin
      chk("R5", "mem req raised", 32'(mem_req_valid_o), 32'd1);
      chk("R5", "mem req addr", 32'(mem_req_addr_o), 32'(a));
      chk("R9", "miss busy", 32'(req_ready_o), 32'd0);
      chk("R1", "miss no early resp", 32'(resp_valid_o), 32'd0);
      dly = $urandom_range(0, 2);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk_i);
        chk("R5", "mem req held", 32'(mem_req_valid_o), 32'd1);
      end
      mem_resp_valid_i = 1'b1;
      mem_resp_data_i  = line_of(a);
      @(negedge clk_i);
      mem_resp_valid_i = 1'b0;
      chk("R5", "miss resp_valid", 32'(resp_valid_o), 32'd1);
      chk("R5", "miss data", resp_data_o, line_of(a));
      chk(ev_v ? "R7" : "R8", "evict_valid", 32'(evict_valid_o), 32'(ev_v));
      if (ev_v) begin
        chk("R7", "evict addr", 32'(evict_addr_o), 32'(ev_a));
        chk("R6", "evict data", evict_data_o, line_of(ev_a));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m_l1_v[i] = 1'b0; m_l1_a[i] = '0; end
    for (int i = 0; i < 4; i++) begin m_vb_v[i] = 1'b0; m_vb_a[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "ready", 32'(req_ready_o), 32'd1);
    chk("R1", "resp_valid", 32'(resp_valid_o), 32'd0);
    chk("R1", "mem_req_valid", 32'(mem_req_valid_o), 32'd0);
    chk("R1", "evict_valid", 32'(evict_valid_o), 32'd0);

    // directed: fill, swap both ways, fill buffer, FIFO overflow
    access(12'h011);
    access(12'h011);
    access(12'h021);   // R6 displaced 011 parked
    access(12'h011);   // R4 swap back
    access(12'h021);   // R4 swap again
    access(12'h011);
    access(12'h031);
    access(12'h041);
    access(12'h051);   // buffer full
    access(12'h061);   // R7 first FIFO eviction
    access(12'h071);
    access(12'h062);   // R6 empty displaced line not parked
    access(12'h072);
    access(12'h081);

    // random mix on three conflicting indices
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      a = {4'h0, 4'($urandom_range(1, 6)), 4'($urandom_range(0, 2))};
      access(a);
    end

    repeat (2) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule